// File: doc/BRIEF.md
# Eight-Channel Memory-to-Memory Transfer Engine

This block moves data between two memory regions on behalf of up to eight independent channels. Each channel holds a source pointer, a destination pointer, a remaining-unit count, a block length and a handful of mode bits. Its trigger comes from either an external request line or an internal peripheral request line, chosen per channel. When a channel is eligible the engine asks for the memory bus, waits for the grant, and then moves units. Each unit is one read phase followed by one write phase. The write carries the data that was just read.

A channel either pushes one unit per bus tenure (step) or a programmed number of units per tenure (block). Request handling is also chosen per channel. In burst handling a single request pulse is latched and the whole count runs to the end. In continuous handling a unit only begins while the request line is high. Units are 8, 16 or 32 bits wide, and both pointers advance by the unit size. A global suspend, raised by either a non-maskable or a maskable interrupt line, prevents any new unit from starting. The engine then gives up the bus after the unit in flight. Work resumes from the same pointers once both lines are low.

Channels are armed through a single-cycle configuration write port.

Top module: `dmx_top`

## Requirements
- R1: A configuration write with `cfg_we` high loads the channel named by `cfg_ch` and clears its done flag. The channel is armed only when the written count is non-zero. No other channel is affected.
- R2: Mode bit 2 selects the trigger source: 0 = `ext_req[ch]`, 1 = `per_req[ch]`. Activity on the unselected line starts no transfer.
- R3: With mode bit 4 = 0 (continuous) and mode bit 3 = 0 (step), each bus tenure (a rising edge of `bus_req`) carries exactly one unit.
- R4: With mode bit 4 = 0 and mode bit 3 = 1 (block), each tenure carries up to `cfg_blk` units (0 counts as 1) while the request is held. A channel of count N therefore needs ceil(N / blk) tenures.
- R5: With mode bit 4 = 1 (burst), a one-cycle request pulse on an armed channel moves the whole count in a single tenure, whatever mode bit 3 says.
- R6: In continuous handling no unit starts while the selected request is low. Dropping the request stops the channel after the unit in flight, and it keeps its remaining count for a later request.
- R7: Mode bits 1:0 give the unit size: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit. `mem_size` shows this code. Unit k reads `src + k*bytes` and writes `dst + k*bytes`.
- R8: While `nmi` or `irq` is high no new unit begins and `bus_req` falls within three cycles. After both lines clear, the transfer continues at the next unit's addresses.
- R9: When several channels are eligible at once, the lowest channel number is served first.
- R10: `mem_valid` is asserted only while `bus_req` and `bus_gnt` are both high. Each write phase (`mem_wr` = 1) follows a read phase, and its `mem_wdata` equals the `mem_rdata` returned by that read.
- R11: Reset clears all done flags and leaves the bus idle. When a channel's count reaches zero, its `done` bit is set and the channel stops requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel being configured |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_cnt | input | 16 | Number of units to move |
| cfg_blk | input | 8 | Units per tenure in block mode |
| cfg_mode | input | 5 | {burst, block, source select, size[1:0]} |
| ext_req | input | 8 | External request line per channel |
| per_req | input | 8 | Peripheral request line per channel |
| nmi | input | 1 | Non-maskable interrupt, suspends transfers |
| irq | input | 1 | Interrupt request, suspends transfers |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_valid | output | 1 | Bus phase active |
| mem_wr | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr | output | 32 | Phase address |
| mem_size | output | 2 | Unit size code of the phase |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Phase completes this cycle |
| done | output | 8 | Per-channel completion flag |

## Verification
A corrupted pointer shows up on the very next write phase as a `mem_addr` that breaks the stride of `mem_size` bytes. A wrong count shows up either as the done bit rising after too few or too many writes, or as a channel that never finishes. A sequencer that loses track of its quantum or of the suspend condition changes the number of `bus_req` rises per transfer, which is visible within one unit time of four cycles. A sequencer that ignores suspend produces writes after `nmi` rises. A mixed-up channel index shows up as the first write landing in the wrong destination window when two channels are triggered together.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} dmx_st_e;

  localparam int MODE_W  = 5;
  localparam int M_SRC   = 2;
  localparam int M_BLK   = 3;
  localparam int M_BURST = 4;

  // bytes per unit from size code
  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // units granted for one tenure
  function automatic logic [7:0] quantum(input logic blk_mode, input logic [7:0] blk);
    if (!blk_mode) return 8'd1;
    return (blk == 8'd0) ? 8'd1 : blk;
  endfunction
endpackage

// File: rtl/dmx_arb.sv
module dmx_arb #(
  parameter int N   = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) win = IW'(i);
    end
  end
  assign any = |elig;
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic [BW-1:0]     cfg_blk,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              ext_req,
  input  logic              per_req,
  input  logic              unit_done,
  output logic [AW-1:0]     src,
  output logic [AW-1:0]     dst,
  output logic [CW-1:0]     cnt,
  output logic [BW-1:0]     blk,
  output logic [1:0]        size,
  output logic              burst,
  output logic              blkm,
  output logic              req_lvl,
  output logic              elig,
  output logic              done
);
  logic src_int, active, pend;

  assign req_lvl = src_int ? per_req : ext_req;
  assign elig    = active & (burst ? (pend | req_lvl) : req_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0; blk <= '0; size <= '0;
      burst <= 1'b0; blkm <= 1'b0; src_int <= 1'b0;
      active <= 1'b0; pend <= 1'b0; done <= 1'b0;
    end else if (cfg_we) begin
      src     <= cfg_src;
      dst     <= cfg_dst;
      cnt     <= cfg_cnt;
      blk     <= cfg_blk;
      size    <= cfg_mode[1:0];
      src_int <= cfg_mode[M_SRC];
      blkm    <= cfg_mode[M_BLK];
      burst   <= cfg_mode[M_BURST];
      active  <= (cfg_cnt != '0);
      pend    <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (active && burst && req_lvl) pend <= 1'b1;
      if (unit_done) begin
        src <= src + AW'(unit_bytes(size));
        dst <= dst + AW'(unit_bytes(size));
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          pend   <= 1'b0;
        end
      end
    end
  end

  // R11: a finished channel is idle with nothing left
  p_done_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!active && cnt == '0));
  // R11: an armed channel always has work left
  p_active_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt != '0);
  // R7: destination moves by exactly one unit per completed unit
  p_dst_stride_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cfg_we) |=> (dst - $past(dst)) == AW'(unit_bytes($past(size))));
  // R1: a served unit only happens on an armed channel
  p_unit_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> active);
endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
  import dmx_pkg::*;
#(
  parameter int N   = 8,
  parameter int BW  = 8,
  parameter int DW  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any,
  input  logic [IW-1:0] win,
  input  logic          susp,
  input  logic          bus_gnt,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          cur_last,
  input  logic          cur_burst,
  input  logic          cur_blkm,
  input  logic [BW-1:0] cur_blk,
  input  logic          cur_req,
  output logic [IW-1:0] cur,
  output logic          bus_req,
  output logic          mem_valid,
  output logic          mem_wr,
  output logic [DW-1:0] wdata,
  output logic          unit_done
);
  dmx_st_e       st;
  logic [BW-1:0] qleft;
  logic          rd_prev;
  logic          rd_begin;
  logic          go_on;

  assign bus_req   = (st != ST_IDLE);
  assign mem_valid = (st == ST_RD) || (st == ST_WR);
  assign mem_wr    = (st == ST_WR);
  assign unit_done = (st == ST_WR) && mem_ready;
  assign rd_begin  = (st == ST_RD) && !rd_prev;
  assign go_on     = !cur_last && !susp && (cur_burst || (qleft > BW'(1) && cur_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cur <= '0; qleft <= '0; wdata <= '0; rd_prev <= 1'b0;
    end else begin
      rd_prev <= (st == ST_RD);
      case (st)
        ST_IDLE: if (any && !susp) begin
          st  <= ST_REQ;
          cur <= win;
        end
        ST_REQ: if (susp) st <= ST_IDLE;
                else if (bus_gnt) begin
                  st    <= ST_RD;
                  qleft <= quantum(cur_blkm, cur_blk);
                end
        ST_RD: if (mem_ready) begin
          wdata <= mem_rdata;
          st    <= ST_WR;
        end
        default: if (mem_ready) begin
          qleft <= qleft - BW'(1);
          st    <= go_on ? ST_RD : ST_IDLE;
        end
      endcase
    end
  end

  // R8: no unit is opened in a cycle following a suspend
  p_no_start_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_begin |-> !$past(susp));
  // R10: every write phase is preceded by a read phase
  p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_valid && !mem_wr));
  // R10: write data is held stable through the write phase
  p_wdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr) && !$past(mem_ready)) |-> $stable(wdata));
endmodule

// File: rtl/dmx_top.sv
module dmx_top
  import dmx_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int BW   = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic [BW-1:0]     cfg_blk,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [NCH-1:0]    ext_req,
  input  logic [NCH-1:0]    per_req,
  input  logic              nmi,
  input  logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_valid,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ready,
  output logic [NCH-1:0]    done
);
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [CW-1:0]  cnt_a [NCH];
  logic [BW-1:0]  blk_a [NCH];
  logic [1:0]     size_a [NCH];
  logic [NCH-1:0] burst_v, blkm_v, req_v, elig_v;
  logic [CHW-1:0] cur, win;
  logic           any, unit_done, susp;

  assign susp = nmi | irq;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmx_chan #(.AW(AW), .CW(CW), .BW(BW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we && cfg_ch == CHW'(i)),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
      .cfg_blk(cfg_blk), .cfg_mode(cfg_mode),
      .ext_req(ext_req[i]), .per_req(per_req[i]),
      .unit_done(unit_done && cur == CHW'(i)),
      .src(src_a[i]), .dst(dst_a[i]), .cnt(cnt_a[i]), .blk(blk_a[i]),
      .size(size_a[i]), .burst(burst_v[i]), .blkm(blkm_v[i]),
      .req_lvl(req_v[i]), .elig(elig_v[i]), .done(done[i])
    );
  end

  dmx_arb #(.N(NCH)) u_arb (.elig(elig_v), .any(any), .win(win));

  dmx_seq #(.N(NCH), .BW(BW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .any(any), .win(win), .susp(susp),
    .bus_gnt(bus_gnt), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .cur_last(cnt_a[cur] == CW'(1)), .cur_burst(burst_v[cur]),
    .cur_blkm(blkm_v[cur]), .cur_blk(blk_a[cur]), .cur_req(req_v[cur]),
    .cur(cur), .bus_req(bus_req), .mem_valid(mem_valid), .mem_wr(mem_wr),
    .wdata(mem_wdata), .unit_done(unit_done)
  );

  assign mem_addr = mem_wr ? dst_a[cur] : src_a[cur];
  assign mem_size = size_a[cur];

  // R10: bus phases only while the bus is owned
  p_bus_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (bus_req && bus_gnt));
  // R8: the bus is released while suspended
  p_release_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(susp) && susp && !$past(mem_valid)) |-> !mem_valid);
endmodule

// File: tb/dmx_top_bench.sv
module dmx_top_bench;
  typedef struct packed {
    logic [2:0] ch; logic [1:0] sz; logic blk; logic burst; logic src_int;
    logic [7:0] cnt; logic [7:0] bsz;
  } vec_t;

  localparam vec_t [0:4] VECS = '{
    '{ch:3'd0, sz:2'd0, blk:1'b0, burst:1'b1, src_int:1'b0, cnt:8'd5, bsz:8'd1},
    '{ch:3'd3, sz:2'd1, blk:1'b1, burst:1'b1, src_int:1'b1, cnt:8'd6, bsz:8'd4},
    '{ch:3'd7, sz:2'd2, blk:1'b0, burst:1'b0, src_int:1'b0, cnt:8'd3, bsz:8'd1},
    '{ch:3'd5, sz:2'd2, blk:1'b1, burst:1'b0, src_int:1'b1, cnt:8'd7, bsz:8'd3},
    '{ch:3'd1, sz:2'd1, blk:1'b0, burst:1'b0, src_int:1'b1, cnt:8'd1, bsz:8'd1}
  };
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_ch = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0; logic [15:0] cfg_cnt = '0;
  logic [7:0] cfg_blk = '0; logic [4:0] cfg_mode = '0;
  logic [7:0] ext_req = '0, per_req = '0;
  logic nmi = 1'b0, irq = 1'b0, gnt_en = 1'b1, mem_ready = 1'b1;
  logic bus_req, bus_gnt, mem_valid, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata; logic [1:0] mem_size; logic [7:0] done;

  assign bus_gnt   = bus_req & gnt_en;
  assign mem_rdata = mem_addr ^ KEY;

  dmx_top u_dmx_top (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_blk(cfg_blk),
    .cfg_mode(cfg_mode), .ext_req(ext_req), .per_req(per_req), .nmi(nmi), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done));

  always #2 clk = ~clk;

  int errs = 0, nchk = 0, nwr = 0, tenures = 0;
  logic prev_br = 1'b0;
  logic [31:0] log_addr [256]; logic [31:0] log_data [256]; logic [1:0] log_size [256];

  always @(negedge clk) begin
    if (mem_valid && mem_wr && mem_ready) begin
      log_addr[nwr % 256] = mem_addr;
      log_data[nwr % 256] = mem_wdata;
      log_size[nwr % 256] = mem_size;
      nwr = nwr + 1;
    end
    if (bus_req && !prev_br) tenures = tenures + 1;
    prev_br = bus_req;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int bytes_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic cfg_write(input logic [2:0] ch, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] n, input logic [7:0] b, input logic [4:0] m);
    @(negedge clk);
    cfg_ch = ch; cfg_src = s; cfg_dst = d; cfg_cnt = n; cfg_blk = b; cfg_mode = m; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_req(input logic [2:0] ch, input logic sel, input logic val);
    if (sel) per_req[ch] = val; else ext_req[ch] = val;
  endtask

  task automatic pulse(input logic [2:0] ch, input logic sel);
    @(negedge clk); set_req(ch, sel, 1'b1);
    @(negedge clk); set_req(ch, sel, 1'b0);
  endtask

  task automatic wait_done(input logic [2:0] ch, input string rq);
    int t = 0;
    while (!done[ch] && t < 3000) begin @(negedge clk); t++; end
    chk(done[ch] == 1'b1, rq, "channel completion", done[ch], 1);
  endtask

  // checks stride, data and size of n writes starting at log index base
  task automatic check_log(input int base, input int n, input logic [31:0] s0,
                           input logic [31:0] d0, input logic [1:0] sz, input string rq);
    int b = bytes_of(sz); int bad_a = 0, bad_d = 0, bad_s = 0;
    for (int k = 0; k < n; k++) begin
      if (log_addr[(base + k) % 256] != d0 + 32'(k * b)) bad_a++;
      if (log_data[(base + k) % 256] != ((s0 + 32'(k * b)) ^ KEY)) bad_d++;
      if (log_size[(base + k) % 256] != sz) bad_s++;
    end
    chk(bad_a == 0, rq, "R7 write addresses off stride", bad_a, 0);
    chk(bad_d == 0, "R10", "write data not equal to read data", bad_d, 0);
    chk(bad_s == 0, "R7", "mem_size code", bad_s, 0);
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] s0, d0; int base, t0, expt; string tq;
    s0 = 32'h1000 + 32'(v.ch) * 256; d0 = 32'h8000 + 32'(v.ch) * 256;
    cfg_write(v.ch, s0, d0, 16'(v.cnt), v.bsz, {v.burst, v.blk, v.src_int, v.sz});
    base = nwr; t0 = tenures;
    tq = v.burst ? "R5" : (v.blk ? "R4" : "R3");
    if (v.burst) pulse(v.ch, v.src_int);
    else begin @(negedge clk); set_req(v.ch, v.src_int, 1'b1); end
    wait_done(v.ch, "R11");
    set_req(v.ch, v.src_int, 1'b0);
    repeat (4) @(negedge clk);
    expt = v.burst ? 1 : (v.blk ? (int'(v.cnt) + int'(v.bsz) - 1) / int'(v.bsz) : int'(v.cnt));
    chk(nwr - base == int'(v.cnt), tq, "units moved", nwr - base, v.cnt);
    chk(tenures - t0 == expt, tq, "bus tenures", tenures - t0, expt);
    check_log(base, v.cnt, s0, d0, v.sz, "R7");
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    int base, n1, t0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(done == 8'h00, "R11", "done after reset", done, 0);
    chk(bus_req == 1'b0 && mem_valid == 1'b0, "R11", "bus idle after reset", bus_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R2: unselected source ignored
    cfg_write(3'd0, 32'h1000, 32'h8000, 16'd2, 8'd1, 5'b10_0_00);
    base = nwr;
    pulse(3'd0, 1'b1);
    repeat (20) @(negedge clk);
    chk(nwr == base && done[0] == 1'b0, "R2", "writes after unselected request", nwr - base, 0);
    pulse(3'd0, 1'b0);
    wait_done(3'd0, "R2");
    chk(nwr - base == 2, "R2", "units after selected request", nwr - base, 2);

    // R6: continuous stops when request drops, resumes later
    cfg_write(3'd2, 32'h1200, 32'h8200, 16'd10, 8'd1, 5'b00_0_00);
    base = nwr;
    @(negedge clk); ext_req[2] = 1'b1;
    repeat (9) @(negedge clk);
    ext_req[2] = 1'b0;
    repeat (5) @(negedge clk);
    n1 = nwr;
    repeat (30) @(negedge clk);
    chk(nwr == n1 && n1 > base && n1 - base < 10, "R6", "writes frozen after drop", nwr - base, n1 - base);
    chk(done[2] == 1'b0, "R6", "done while work remains", done[2], 0);
    ext_req[2] = 1'b1;
    wait_done(3'd2, "R6");
    ext_req[2] = 1'b0;
    chk(nwr - base == 10, "R6", "total units after resume", nwr - base, 10);
    check_log(base, 10, 32'h1200, 32'h8200, 2'd0, "R6");

    // R8: suspend by nmi then irq
    cfg_write(3'd4, 32'h1400, 32'h8400, 16'd20, 8'd1, 5'b10_0_10);
    base = nwr;
    pulse(3'd4, 1'b0);
    repeat (10) @(negedge clk);
    nmi = 1'b1;
    repeat (4) @(negedge clk);
    n1 = nwr;
    chk(bus_req == 1'b0, "R8", "bus_req during nmi", bus_req, 0);
    repeat (30) @(negedge clk);
    chk(nwr == n1, "R8", "writes during nmi", nwr - n1, 0);
    nmi = 1'b0;
    repeat (8) @(negedge clk);
    irq = 1'b1;
    repeat (4) @(negedge clk);
    n1 = nwr;
    repeat (20) @(negedge clk);
    chk(nwr == n1 && bus_req == 1'b0, "R8", "writes during irq", nwr - n1, 0);
    irq = 1'b0;
    wait_done(3'd4, "R8");
    chk(nwr - base == 20, "R8", "units after resume", nwr - base, 20);
    check_log(base, 20, 32'h1400, 32'h8400, 2'd2, "R8");

    // R1 / R9: rearm clears done; lower channel wins
    cfg_write(3'd6, 32'h1600, 32'h8600, 16'd3, 8'd1, 5'b10_0_00);
    cfg_write(3'd2, 32'h1200, 32'h8200, 16'd3, 8'd1, 5'b10_0_00);
    chk(done[2] == 1'b0 && done[4] == 1'b1, "R1", "done after rearm", done, 8'h10);
    base = nwr;
    @(negedge clk); ext_req[6] = 1'b1; ext_req[2] = 1'b1;
    @(negedge clk); ext_req[6] = 1'b0; ext_req[2] = 1'b0;
    wait_done(3'd6, "R9");
    chk(log_addr[base % 256] == 32'h8200, "R9", "first write address", log_addr[base % 256], 32'h8200);
    chk(log_addr[(base + 3) % 256] == 32'h8600, "R9", "first write of higher channel",
        log_addr[(base + 3) % 256], 32'h8600);

    // R10: nothing moves without grant
    gnt_en = 1'b0;
    cfg_write(3'd3, 32'h1300, 32'h8300, 16'd1, 8'd1, 5'b10_0_10);
    base = nwr; t0 = 0;
    pulse(3'd3, 1'b0);
    for (int c = 0; c < 10; c++) begin @(negedge clk); if (mem_valid) t0++; end
    chk(t0 == 0 && bus_req == 1'b1, "R10", "phases without grant", t0, 0);
    gnt_en = 1'b1;
    wait_done(3'd3, "R10");
    check_log(base, 1, 32'h1300, 32'h8300, 2'd2, "R10");

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule